// File: doc/BRIEF.md
# Partitioned LRU Way-Replacement Controller

This block holds the replacement state for a four-way set-associative read cache that sits in front of flash memory. For every set it keeps a valid bit per way and a full recency ordering of the four ways. When a lookup misses, it names the way that the next line fill should overwrite, and it reports whether a fill is permitted at all.

A 3-bit mode input decides which ways each access type may replace. The ways can be shared by instruction fetches and data reads, or split between the two. When the ways are split, each side keeps its own least-recently-used order. Lock and enable inputs can forbid fills. A one-cycle, per-way invalidate strobe empties a way in every set at once. The tag and data arrays, the flash port and the register decode that drives the mode, lock, enable and invalidate inputs all sit outside this block.

The victim outputs are combinational from `set_i`, `is_data_i` and the stored state. A hit or fill event is applied at the next rising clock edge.

Top module: `lru_repl_ctrl`

## Requirements
- R1: After reset every way of every set is invalid, and the recency order of each set from most to least recent is way 0, 1, 2, 3.
- R2: In mode 3'b000 both access types may replace any of the four ways, and they share one recency order per set.
- R3: In mode 3'b010 an instruction fetch (`is_data_i`=0) may replace only ways 0 and 1, and a data read (`is_data_i`=1) may replace only ways 2 and 3.
- R4: In mode 3'b011 an instruction fetch may replace only ways 0, 1 and 2, and a data read may replace only way 3.
- R5: The mode codes 3'b001, 3'b100, 3'b101, 3'b110 and 3'b111 allow no fill: `fill_ok_o` is 0.
- R6: Among the ways that may be replaced, an invalid way is chosen before any valid way, and the lowest-numbered invalid way is chosen first.
- R7: When every way that may be replaced is valid, the victim is the one among them that was used least recently.
- R8: A hit (`hit_i`) or a completed fill (`fill_i`) on `way_i` of set `set_i` makes that way the most recent of its set from the next clock edge. A fill also marks the way valid.
- R9: A way whose `lock_i` bit is 1 is never the victim. If no replaceable way is left, `fill_ok_o` is 0 and `victim_o` is 0.
- R10: When `dcache_en_i` is 0, data reads get `fill_ok_o`=0. When `icache_en_i` is 0, instruction fetches get `fill_ok_o`=0.
- R11: A 1 on bit w of `inv_i` makes way w invalid in every set from the next clock edge, even while that way is locked.
- R12: If an invalidate of a way and a fill to the same way happen in the same cycle, the way ends up invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Replacement mode code |
| icache_en_i | input | 1 | Allows instruction fetches to allocate |
| dcache_en_i | input | 1 | Allows data reads to allocate |
| lock_i | input | 4 | Per-way lock mask |
| inv_i | input | 4 | Per-way invalidate strobe, one cycle |
| set_i | input | SET_W | Set index for the lookup and the event |
| is_data_i | input | 1 | Access type: 1 = data read, 0 = instruction fetch |
| hit_i | input | 1 | Hit event on `way_i` |
| fill_i | input | 1 | Fill-complete event on `way_i` |
| way_i | input | 2 | Way named by the hit or fill event |
| victim_o | output | 2 | Way to replace on a miss |
| fill_ok_o | output | 1 | A fill is permitted for this lookup |

## Verification
The checker assumes a few things about the inputs. `hit_i` and `fill_i` are never raised together. A hit names a way that is valid in that set. A fill names the victim that the block reported in the same cycle. The checker assumes nothing about the mode, lock or enable inputs, because its properties relate those inputs directly to `victim_o` and `fill_ok_o`. The stimulus follows these assumptions: it raises a hit only on a way that the bench's own model holds as valid, and a fill only when that model allows one, on the way the model chose. It changes the mode, the locks, the enables and the invalidates freely, including reserved codes and fills that coincide with an invalidate.

// File: rtl/lru_repl_pkg.sv
package lru_repl_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0]            way_t;
  typedef logic [WAYS-1:0]             wmask_t;
  typedef logic [WAYS-1:0][WAY_W-1:0]  rank_vec_t;

  typedef enum logic [2:0] {
    MODE_SHARED  = 3'b000,
    MODE_SPLIT22 = 3'b010,
    MODE_SPLIT31 = 3'b011
  } repl_mode_e;

  // rank 0 = most recent; reset order way0 newest .. way3 oldest
  localparam rank_vec_t RANK_INIT = {2'd3, 2'd2, 2'd1, 2'd0};
endpackage

// File: rtl/lru_part_decode.sv
module lru_part_decode
  import lru_repl_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       is_data_i,
  output wmask_t     allowed_o,
  output logic       mode_ok_o
);
  always_comb begin
    allowed_o = '0;
    mode_ok_o = 1'b1;
    case (mode_i)
      MODE_SHARED:  allowed_o = 4'b1111;
      MODE_SPLIT22: allowed_o = is_data_i ? 4'b1100 : 4'b0011;
      MODE_SPLIT31: allowed_o = is_data_i ? 4'b1000 : 4'b0111;
      default: begin
        allowed_o = '0;
        mode_ok_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lru_rank_store.sv
module lru_rank_store
  import lru_repl_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int SET_W    = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  wmask_t           inv_i,
  input  logic             touch_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] set_i,
  input  way_t             way_i,
  output rank_vec_t        ranks_o,
  output wmask_t           valid_o
);
  rank_vec_t rank_all [NUM_SETS];
  wmask_t    vld_all  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    rank_vec_t rank_q, rank_d;
    wmask_t    vld_q, vld_d;
    logic      hit_set;
    logic      en;

    assign hit_set = (set_i == SET_W'(s)) && touch_i;
    assign en      = hit_set || (|inv_i);

    always_comb begin
      rank_d = rank_q;
      vld_d  = vld_q;
      if (hit_set) begin
        for (int k = 0; k < WAYS; k++) begin
          if (way_t'(k) == way_i)
            rank_d[k] = '0;
          else if (rank_q[k] < rank_q[way_i])
            rank_d[k] = rank_q[k] + 2'd1;
        end
        if (fill_i)
          vld_d[way_i] = 1'b1;
      end
      // invalidate wins over a same-cycle fill and over any lock
      vld_d = vld_d & ~inv_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q <= RANK_INIT;
        vld_q  <= '0;
      end else if (en) begin
        rank_q <= rank_d;
        vld_q  <= vld_d;
      end
    end

    assign rank_all[s] = rank_q;
    assign vld_all[s]  = vld_q;
  end

  assign ranks_o = rank_all[set_i];
  assign valid_o = vld_all[set_i];
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
  import lru_repl_pkg::*;
(
  input  rank_vec_t ranks_i,
  input  wmask_t    valid_i,
  input  wmask_t    cand_i,
  output way_t      victim_o,
  output logic      found_o
);
  wmask_t     empty;
  logic [1:0] best;

  always_comb begin
    empty    = cand_i & ~valid_i;
    found_o  = |cand_i;
    victim_o = '0;
    best     = '0;
    if (|empty) begin
      for (int k = WAYS - 1; k >= 0; k--)
        if (empty[k]) victim_o = way_t'(k);
    end else begin
      for (int k = 0; k < WAYS; k++) begin
        if (cand_i[k] && (ranks_i[k] >= best)) begin
          best     = ranks_i[k];
          victim_o = way_t'(k);
        end
      end
    end
  end
endmodule

// File: rtl/lru_repl_ctrl.sv
module lru_repl_ctrl
  import lru_repl_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             icache_en_i,
  input  logic             dcache_en_i,
  input  logic [3:0]       lock_i,
  input  logic [3:0]       inv_i,
  input  logic [SET_W-1:0] set_i,
  input  logic             is_data_i,
  input  logic             hit_i,
  input  logic             fill_i,
  input  logic [1:0]       way_i,
  output logic [1:0]       victim_o,
  output logic             fill_ok_o
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  wmask_t    allowed, cand, cur_valid;
  logic      mode_ok, type_en;
  rank_vec_t cur_ranks;
  way_t      pick_way;
  logic      pick_found;

  lru_part_decode u_dec (
    .mode_i    (mode_i),
    .is_data_i (is_data_i),
    .allowed_o (allowed),
    .mode_ok_o (mode_ok)
  );

  lru_rank_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .inv_i   (inv_i),
    .touch_i (hit_i | fill_i),
    .fill_i  (fill_i),
    .set_i   (set_i),
    .way_i   (way_i),
    .ranks_o (cur_ranks),
    .valid_o (cur_valid)
  );

  assign type_en = is_data_i ? dcache_en_i : icache_en_i;
  assign cand    = allowed & ~lock_i & {WAYS{mode_ok & type_en}};

  lru_victim_pick u_pick (
    .ranks_i  (cur_ranks),
    .valid_i  (cur_valid),
    .cand_i   (cand),
    .victim_o (pick_way),
    .found_o  (pick_found)
  );

  assign fill_ok_o = pick_found;
  assign victim_o  = pick_found ? pick_way : '0;
endmodule

// File: rtl/lru_repl_chk.sv
module lru_repl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       icache_en_i,
  input logic       dcache_en_i,
  input logic [3:0] lock_i,
  input logic       is_data_i,
  input logic [1:0] victim_o,
  input logic       fill_ok_o
);
  assert_split22_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b010 && fill_ok_o) |-> (victim_o[1] == is_data_i));

  assert_split31_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b011 && fill_ok_o) |-> ((victim_o == 2'd3) == is_data_i));

  assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b001 || mode_i[2]) |-> !fill_ok_o);

  assert_no_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok_o |-> !lock_i[victim_o]);

  assert_idle_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ok_o |-> (victim_o == 2'd0));

  assert_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data_i ? !dcache_en_i : !icache_en_i) |-> !fill_ok_o);
endmodule

bind lru_repl_ctrl lru_repl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .icache_en_i (icache_en_i),
  .dcache_en_i (dcache_en_i),
  .lock_i      (lock_i),
  .is_data_i   (is_data_i),
  .victim_o    (victim_o),
  .fill_ok_o   (fill_ok_o)
);

// File: tb/sim_lru_repl_ctrl.sv
`timescale 1ns/1ps
module sim_lru_repl_ctrl;
  localparam int NUM_SETS = 16;
  localparam int SET_W    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode;
  logic ice, dce;
  logic [3:0] lock, inv;
  logic [SET_W-1:0] set;
  logic is_data, hit, fill;
  logic [1:0] way;
  logic [1:0] victim;
  logic fill_ok;

  always #5 clk = ~clk;

  lru_repl_ctrl #(.NUM_SETS(NUM_SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .icache_en_i(ice),
    .dcache_en_i(dce), .lock_i(lock), .inv_i(inv), .set_i(set),
    .is_data_i(is_data), .hit_i(hit), .fill_i(fill), .way_i(way),
    .victim_o(victim), .fill_ok_o(fill_ok)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // behavioural reference: recency queue per set (front = newest)
  int       rec  [NUM_SETS][$];
  bit [3:0] mvld [NUM_SETS];

  function automatic void model_reset();
    for (int s = 0; s < NUM_SETS; s++) begin
      rec[s] = {0, 1, 2, 3};
      mvld[s] = 4'b0;
    end
  endfunction

  function automatic void model_pick(input int s, input bit d,
                                     output bit ok, output int v, output string why);
    bit [3:0] allow, cand;
    bit en;
    ok = 0; v = 0;
    case (mode)
      3'b000: allow = 4'hF;
      3'b010: allow = d ? 4'hC : 4'h3;
      3'b011: allow = d ? 4'h8 : 4'h7;
      default: allow = 4'h0;
    endcase
    en = d ? dce : ice;
    cand = en ? (allow & ~lock) : 4'h0;
    if (allow == 0) begin why = "R5"; return; end
    if (!en)        begin why = "R10"; return; end
    if (cand == 0)  begin why = "R9"; return; end
    ok = 1;
    for (int k = 0; k < 4; k++)
      if (cand[k] && !mvld[s][k]) begin v = k; why = "R6"; return; end
    why = "R7";
    for (int i = 3; i >= 0; i--)
      if (cand[rec[s][i]]) begin v = rec[s][i]; return; end
  endfunction

  function automatic void model_update();
    if (hit || fill) begin
      int w = int'(way);
      int s = int'(set);
      for (int i = 0; i < rec[s].size(); i++)
        if (rec[s][i] == w) begin rec[s].delete(i); break; end
      rec[s].push_front(w);
      if (fill) mvld[s][w] = 1'b1;
    end
    for (int s = 0; s < NUM_SETS; s++) mvld[s] &= ~inv;
  endfunction

  // drive at negedge, compare just before posedge, then advance model
  task automatic step(input int s, input bit d, input bit h, input bit f,
                      input int w, input bit [3:0] iv, input string tag);
    bit eok; int ev; string why;
    @(negedge clk);
    set = SET_W'(s); is_data = d; hit = h; fill = f; way = 2'(w); inv = iv;
    #4;
    model_pick(s, d, eok, ev, why);
    if (tag != "") why = tag;
    n_checks++;
    if (victim !== 2'(ev) || fill_ok !== eok) begin
      n_fails++;
      $display("FAIL %s: set=%0d data=%0d victim=%0d fill_ok=%0d expected victim=%0d fill_ok=%0d",
               why, s, d, victim, fill_ok, ev, eok);
    end
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; mode = 3'b000; ice = 1; dce = 1; lock = 0; inv = 0;
    set = 0; is_data = 0; hit = 0; fill = 0; way = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: empty after reset, lowest way offered
    step(0, 0, 0, 0, 0, 0, "R1");
    step(9, 1, 0, 0, 0, 0, "R1");
    // R6 / R8: fill set 3 in order, watch the next invalid way
    step(3, 0, 0, 1, 0, 0, "R8");
    step(3, 0, 0, 1, 1, 0, "R6");
    step(3, 0, 0, 1, 2, 0, "R6");
    step(3, 0, 0, 1, 3, 0, "R6");
    step(3, 0, 0, 0, 0, 0, "R7");   // expect way 0 as oldest
    step(3, 0, 1, 0, 0, 0, "R8");   // hit way 0
    step(3, 1, 0, 0, 0, 0, "R2");   // expect way 1, shared order
    // R3
    mode = 3'b010;
    step(3, 1, 0, 0, 0, 0, "R3");
    step(3, 0, 0, 0, 0, 0, "R3");
    // R4
    mode = 3'b011;
    step(3, 1, 0, 0, 0, 0, "R4");
    step(3, 0, 0, 0, 0, 0, "R4");
    // R5
    mode = 3'b100; step(3, 0, 0, 0, 0, 0, "R5");
    mode = 3'b001; step(3, 1, 0, 0, 0, 0, "R5");
    mode = 3'b111; step(3, 1, 0, 0, 0, 0, "R5");
    // R9
    mode = 3'b010; lock = 4'b0011;
    step(3, 0, 0, 0, 0, 0, "R9");
    step(3, 1, 0, 0, 0, 0, "R9");
    mode = 3'b000; lock = 4'b1101;
    step(3, 0, 0, 0, 0, 0, "R9");
    // R10
    lock = 0; dce = 0;
    step(3, 1, 0, 0, 0, 0, "R10");
    step(3, 0, 0, 0, 0, 0, "R10");
    dce = 1; ice = 0;
    step(3, 0, 0, 0, 0, 0, "R10");
    step(3, 1, 0, 0, 0, 0, "R10");
    ice = 1;
    // R11: invalidate a locked way, then release the lock
    lock = 4'b0010;
    step(3, 0, 0, 0, 0, 4'b0010, "R11");
    lock = 0;
    step(3, 0, 0, 0, 0, 0, "R11");
    // R12: fill and invalidate the same way together
    step(3, 0, 0, 1, 1, 4'b0010, "R12");
    step(3, 0, 0, 0, 0, 0, "R12");

    // mixed traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int s; bit d, h, f; int w; bit [3:0] iv;
      bit eok; int ev; string why;
      if ($urandom_range(0, 19) == 0) begin
        case ($urandom_range(0, 5))
          0, 1: mode = 3'b000;
          2:    mode = 3'b010;
          3:    mode = 3'b011;
          4:    mode = 3'($urandom_range(4, 7));
          default: mode = 3'b001;
        endcase
      end
      if ($urandom_range(0, 24) == 0) lock = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      if ($urandom_range(0, 39) == 0) ice = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 39) == 0) dce = ($urandom_range(0, 3) != 0);
      s = $urandom_range(0, 5);
      d = $urandom_range(0, 1);
      iv = ($urandom_range(0, 29) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'b0;
      h = 0; f = 0; w = 0;
      model_pick(s, d, eok, ev, why);
      if ($urandom_range(0, 1) == 0) begin
        w = $urandom_range(0, 3);
        if (mvld[s][w]) h = 1;
      end else if (eok) begin
        f = 1; w = ev;
      end
      step(s, d, h, f, w, iv, "");
    end
    finish_run();
  end
endmodule